// File: doc/BRIEF.md
# Stack Push/Pull Instruction Sequencer

This block runs the four one-byte stack instructions of an 8-bit accumulator processor: store the accumulator on the stack, store the status byte on the stack, load the accumulator from the stack, and load the status byte from the stack. The surrounding core fetches an opcode and, while the sequencer is idle, presents it with `op_valid`. The sequencer decodes it, and for one of the four stack opcodes it drives the memory bus cycle by cycle, including the dummy reads. When it is done it raises `fetch` so that the core can begin the next opcode fetch. Any other opcode is ignored.

The 8-bit stack pointer belongs to this block, and the stack lives in one fixed memory page (page 1 by default). The accumulator and status registers stay in the core. The sequencer reads them through `acc_in` and `flags_in` and returns new values through write strobes. The status byte layout is bit 7 N (negative), bit 6 V (overflow), bit 5 always 1, bit 4 B (break), bit 3 D (decimal), bit 2 I (interrupt disable), bit 1 Z (zero), bit 0 C (carry). Memory is assumed to return read data one cycle after the address.

The state machine has six states:

| State | What happens | Next state |
|---|---|---|
| `ST_IDLE` | Waits for an accepted opcode. | `ST_DUMMY` on an accepted opcode |
| `ST_DUMMY` | Dummy read at `pc`. | `ST_STORE` for a push, `ST_PULL_INC` for a pull |
| `ST_STORE` | Writes to the stack. | `ST_DONE` |
| `ST_PULL_INC` | First stack read, then SP increments. | `ST_PULL_RD` |
| `ST_PULL_RD` | Reads at the new SP. | `ST_DONE` |
| `ST_DONE` | Fetch cycle; a pull writes back here. | `ST_IDLE` |

Top module: `stack_op_seq`

## Requirements
- R1: Only opcodes 0x48 (push accumulator), 0x08 (push status), 0x68 (pull accumulator) and 0x28 (pull status) start a sequence. Any other opcode with `op_valid` produces no write, no `fetch` and no writeback, and leaves SP unchanged.
- R2: During and after reset, SP is 0xFD, `bus_we` and `fetch` are 0, and `bus_addr` equals `pc`.
- R3: A push takes three cycles after acceptance. Cycle 0 is a read at `pc`. Cycle 1 writes at {page, SP}. Cycle 2 raises `fetch` with `bus_addr` = `pc`.
- R4: A push decrements SP by one after its store cycle, wrapping from 0x00 to 0xFF.
- R5: A pull takes four cycles after acceptance. Cycle 0 reads at `pc`. Cycle 1 reads at {page, SP}. Cycle 2 reads at {page, SP+1}. Cycle 3 raises `fetch` with `bus_addr` = `pc` and uses the byte returned by memory.
- R6: A pull increments SP by one after its cycle 1, wrapping from 0xFF to 0x00.
- R7: Pull accumulator pulses `acc_wr` with the pulled byte and pulses `flags_wr`. In the flag byte, bit 7 is the byte's bit 7, bit 1 is 1 only if the byte is zero, bit 5 is 1, and the other bits come from `flags_in`.
- R8: Push status writes `flags_in` with bits 5 and 4 forced to 1. For example, with only D and Z set the stored byte is 0x3A.
- R9: Pull status pulses `flags_wr` with bits 7, 6, 3, 2, 1 and 0 from the pulled byte, bit 5 set to 1, and bit 4 from `flags_in`. `acc_wr` stays 0.
- R10: `bus_we` is 1 only in the single store cycle of a push, and every other cycle is a read.
- R11: Push accumulator writes `acc_in` to the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode presented; taken only in `ST_IDLE` |
| opcode | input | 8 | Opcode byte |
| pc | input | ADDR_W | Program counter after the opcode byte |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current status byte |
| bus_rdata | input | 8 | Read data, one cycle after its address |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Write data, valid when `bus_we` is 1 |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| fetch | output | 1 | Final cycle: the next opcode fetch starts here |
| acc_wr | output | 1 | Accumulator writeback strobe |
| acc_wdata | output | 8 | New accumulator value |
| flags_wr | output | 1 | Status writeback strobe |
| flags_wdata | output | 8 | New status byte |
| sp | output | 8 | Stack pointer |

## Verification
The bench builds the block with its default parameters: a 16-bit address, stack page 1 and a reset SP of 0xFD. Starting from 0xFD, three pulls in a row carry SP up across 0xFF into 0x00, so the pull read at address 0x0100 and the upward wrap are reached quickly. The push that follows carries SP back down from 0x00 to 0xFF. The status tests give `flags_in` a break bit that differs from the pulled or pushed byte, so the rules for bits 4 and 5 can be seen at the ports.

// File: rtl/stack_op_pkg.sv
package stack_op_pkg;

    localparam int BYTE_W = 8;

    // Positions of the bits in the status byte
    localparam int BIT_N   = 7;
    localparam int BIT_ONE = 5;
    localparam int BIT_BRK = 4;
    localparam int BIT_Z   = 1;

    // Decode pattern: bit 5 selects pull, bit 6 selects accumulator
    localparam logic [7:0] OP_MASK  = 8'h9F;
    localparam logic [7:0] OP_MATCH = 8'h08;
    localparam int OP_PULL_BIT = 5;
    localparam int OP_ACC_BIT  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_STORE,
        ST_PULL_INC,
        ST_PULL_RD,
        ST_DONE
    } stk_state_e;

endpackage

// File: rtl/stack_op_decode.sv
module stack_op_decode
    import stack_op_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       hit,
    output logic       is_pull,
    output logic       is_acc
);
    always_comb begin
        hit     = ((opcode & OP_MASK) == OP_MATCH);
        is_pull = opcode[OP_PULL_BIT];
        is_acc  = opcode[OP_ACC_BIT];
    end
endmodule

// File: rtl/stack_op_sp.sv
module stack_op_sp #(
    parameter logic [7:0] SP_RESET = 8'hFD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec,
    input  logic       inc,
    output logic [7:0] sp
);
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_RESET;
        else if (dec) sp <= sp - 8'd1;
        else if (inc) sp <= sp + 8'd1;
    end
endmodule

// File: rtl/stack_op_flags.sv
module stack_op_flags
    import stack_op_pkg::*;
(
    input  logic [7:0] cur_flags,
    input  logic [7:0] rdata,
    output logic [7:0] push_byte,
    output logic [7:0] pulled_status,
    output logic [7:0] pulled_acc_flags
);
    always_comb begin
        push_byte          = cur_flags;
        push_byte[BIT_ONE] = 1'b1;
        push_byte[BIT_BRK] = 1'b1;

        pulled_status          = rdata;
        pulled_status[BIT_ONE] = 1'b1;
        pulled_status[BIT_BRK] = cur_flags[BIT_BRK];

        pulled_acc_flags          = cur_flags;
        pulled_acc_flags[BIT_ONE] = 1'b1;
        pulled_acc_flags[BIT_N]   = rdata[7];
        pulled_acc_flags[BIT_Z]   = (rdata == 8'h00);
    end
endmodule

// File: rtl/stack_op_seq.sv
module stack_op_seq
    import stack_op_pkg::*;
#(
    parameter int               ADDR_W     = 16,
    parameter logic [7:0]       SP_RESET   = 8'hFD,
    parameter logic [ADDR_W-9:0] STACK_PAGE = 'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] pc,
    input  logic [7:0]        acc_in,
    input  logic [7:0]        flags_in,
    input  logic [7:0]        bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              fetch,
    output logic              acc_wr,
    output logic [7:0]        acc_wdata,
    output logic              flags_wr,
    output logic [7:0]        flags_wdata,
    output logic [7:0]        sp
);
    localparam int PAGE_W = ADDR_W - BYTE_W;

    stk_state_e state, state_nx;
    logic       kind_pull, kind_acc;
    logic       dec_hit, dec_pull, dec_acc;
    logic       sp_dec, sp_inc;
    logic [7:0] push_byte, pulled_status, pulled_acc_flags;
    logic [PAGE_W+7:0] stack_addr;

    stack_op_decode u_dec (
        .opcode  (opcode),
        .hit     (dec_hit),
        .is_pull (dec_pull),
        .is_acc  (dec_acc)
    );

    stack_op_sp #(.SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .inc   (sp_inc),
        .sp    (sp)
    );

    stack_op_flags u_flags (
        .cur_flags        (flags_in),
        .rdata            (bus_rdata),
        .push_byte        (push_byte),
        .pulled_status    (pulled_status),
        .pulled_acc_flags (pulled_acc_flags)
    );

    assign stack_addr = {STACK_PAGE, sp};
    assign sp_dec     = (state == ST_STORE);
    assign sp_inc     = (state == ST_PULL_INC);

    // State register and latched instruction kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind_pull <= 1'b0;
            kind_acc  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && op_valid && dec_hit) begin
                kind_pull <= dec_pull;
                kind_acc  <= dec_acc;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (op_valid && dec_hit) state_nx = ST_DUMMY;
            ST_DUMMY:    state_nx = kind_pull ? ST_PULL_INC : ST_STORE;
            ST_STORE:    state_nx = ST_DONE;
            ST_PULL_INC: state_nx = ST_PULL_RD;
            ST_PULL_RD:  state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Bus and writeback outputs
    always_comb begin
        bus_addr    = pc;
        bus_wdata   = 8'h00;
        bus_we      = 1'b0;
        fetch       = 1'b0;
        acc_wr      = 1'b0;
        acc_wdata   = bus_rdata;
        flags_wr    = 1'b0;
        flags_wdata = 8'h00;
        unique case (state)
            ST_IDLE, ST_DUMMY: bus_addr = pc;
            ST_STORE: begin
                bus_addr  = stack_addr;
                bus_we    = 1'b1;
                bus_wdata = kind_acc ? acc_in : push_byte;
            end
            ST_PULL_INC, ST_PULL_RD: bus_addr = stack_addr;
            ST_DONE: begin
                fetch = 1'b1;
                if (kind_pull) begin
                    flags_wr    = 1'b1;
                    acc_wr      = kind_acc;
                    flags_wdata = kind_acc ? pulled_acc_flags : pulled_status;
                end
            end
            default: bus_addr = pc;
        endcase
    end
endmodule

// File: rtl/stack_op_seq_chk.sv
module stack_op_seq_chk #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-9:0] STACK_PAGE = 'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc,
    input logic [7:0]        flags_in,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              fetch,
    input logic              acc_wr,
    input logic [7:0]        acc_wdata,
    input logic              flags_wr,
    input logic [7:0]        flags_wdata,
    input logic [7:0]        sp
);
    // R10
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we);

    // R3
    we_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> bus_addr[ADDR_W-1:8] == STACK_PAGE);

    // R3
    fetch_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> fetch);

    // R4
    sp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> sp == 8'($past(sp) - 8'd1));

    // R5
    fetch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> (bus_addr == pc) && !bus_we);

    // R9
    flags_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_wr |-> flags_wdata[5] && (flags_wdata[4] == flags_in[4]));

    // R7
    acc_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> flags_wr && (flags_wdata[7] == acc_wdata[7])
                   && (flags_wdata[1] == (acc_wdata == 8'h00)));
endmodule

bind stack_op_seq stack_op_seq_chk #(
    .ADDR_W     (ADDR_W),
    .STACK_PAGE (STACK_PAGE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc          (pc),
    .flags_in    (flags_in),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .fetch       (fetch),
    .acc_wr      (acc_wr),
    .acc_wdata   (acc_wdata),
    .flags_wr    (flags_wr),
    .flags_wdata (flags_wdata),
    .sp          (sp)
);

// File: tb/stack_op_seq_bench.sv
`timescale 1ns/1ps
module stack_op_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc = 16'h8001;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  flags_in = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we, fetch, acc_wr, flags_wr;
    logic [7:0]  acc_wdata, flags_wdata, sp;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_sp = 8'hFD;
    logic [7:0] mem [0:255];

    always #4 clk = ~clk;

    stack_op_seq u_stack_op_seq (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .pc(pc), .acc_in(acc_in), .flags_in(flags_in), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .fetch(fetch), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .flags_wr(flags_wr), .flags_wdata(flags_wdata), .sp(sp)
    );

    // Page-1 RAM with one-cycle read latency; other pages read as 0xEA
    always @(posedge clk) begin
        if (bus_addr[15:8] == 8'h01) begin
            if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
            bus_rdata <= mem[bus_addr[7:0]];
        end else begin
            bus_rdata <= 8'hEA;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_op(input logic [7:0] op);
        @(negedge clk);
        op_valid = 1'b1;
        opcode   = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_push(input logic [7:0] op, input logic [7:0] exp_byte, input string tag);
        logic [7:0] s0;
        s0 = exp_sp;
        start_op(op);
        chk("R3 dummy address", bus_addr, pc);
        chk("R10 dummy is read", {15'd0, bus_we}, 16'd0);
        @(negedge clk);
        chk("R3 store address", bus_addr, {8'h01, s0});
        chk("R10 store is write", {15'd0, bus_we}, 16'd1);
        chk(tag, {8'd0, bus_wdata}, {8'd0, exp_byte});
        @(negedge clk);
        chk("R3 fetch raised", {15'd0, fetch}, 16'd1);
        chk("R3 fetch address", bus_addr, pc);
        chk("R10 fetch is read", {15'd0, bus_we}, 16'd0);
        chk("R4 sp after push", {8'd0, sp}, {8'd0, 8'(s0 - 8'd1)});
        exp_sp = s0 - 8'd1;
        @(negedge clk);
        chk("R3 idle again", {15'd0, fetch}, 16'd0);
        chk("R3 memory holds pushed byte", {8'd0, mem[s0]}, {8'd0, exp_byte});
    endtask

    task automatic do_pull(input logic [7:0] op, input logic is_acc, input logic [7:0] exp_val,
                           input logic [7:0] exp_flags, input string tag);
        logic [7:0] s0;
        s0 = exp_sp;
        start_op(op);
        chk("R5 dummy address", bus_addr, pc);
        chk("R10 pull dummy is read", {15'd0, bus_we}, 16'd0);
        @(negedge clk);
        chk("R5 first stack read", bus_addr, {8'h01, s0});
        chk("R10 pull read", {15'd0, bus_we}, 16'd0);
        @(negedge clk);
        chk("R6 second stack read", bus_addr, {8'h01, 8'(s0 + 8'd1)});
        chk("R6 sp after increment", {8'd0, sp}, {8'd0, 8'(s0 + 8'd1)});
        @(negedge clk);
        chk("R5 fetch raised", {15'd0, fetch}, 16'd1);
        chk("R5 fetch address", bus_addr, pc);
        chk("R9 acc strobe", {15'd0, acc_wr}, {15'd0, is_acc});
        chk("R7 flags strobe", {15'd0, flags_wr}, 16'd1);
        chk(tag, {8'd0, flags_wdata}, {8'd0, exp_flags});
        if (is_acc) chk("R7 pulled accumulator", {8'd0, acc_wdata}, {8'd0, exp_val});
        exp_sp = s0 + 8'd1;
        @(negedge clk);
        chk("R5 idle again", {14'd0, fetch, flags_wr}, 16'd0);
        chk("R6 sp stable", {8'd0, sp}, {8'd0, exp_sp});
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk("R2 sp in reset", {8'd0, sp}, 16'h00FD);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 sp after reset", {8'd0, sp}, 16'h00FD);
        chk("R2 no write", {15'd0, bus_we}, 16'd0);
        chk("R2 no fetch", {15'd0, fetch}, 16'd0);
        chk("R2 address is pc", bus_addr, pc);
    endtask

    task automatic test_ignored(input logic [7:0] op);
        start_op(op);
        for (int i = 0; i < 4; i++) begin
            chk("R1 ignored opcode activity", {12'd0, bus_we, fetch, acc_wr, flags_wr}, 16'd0);
            chk("R1 ignored opcode sp", {8'd0, sp}, {8'd0, exp_sp});
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        test_reset();
        test_ignored(8'hEA);
        test_ignored(8'h88);
        test_ignored(8'h18);

        pc = 16'h8003; acc_in = 8'h89;
        do_push(8'h48, 8'h89, "R11 pushed accumulator");
        pc = 16'h8004; flags_in = 8'h0A;
        do_push(8'h08, 8'h3A, "R8 pushed status D and Z");
        pc = 16'h8009; flags_in = 8'hC4;
        do_pull(8'h28, 1'b0, 8'h00, 8'h2A, "R9 pulled status keeps break");
        pc = 16'h800A;
        do_pull(8'h68, 1'b1, 8'h89, 8'hE4, "R7 pulled accumulator flags negative");
        mem[8'hFE] = 8'h00; flags_in = 8'h91; pc = 16'h9000;
        do_pull(8'h68, 1'b1, 8'h00, 8'h33, "R7 pulled accumulator flags zero");
        mem[8'hFF] = 8'h55; flags_in = 8'h00; pc = 16'h9001;
        do_pull(8'h68, 1'b1, 8'h55, 8'h20, "R7 pulled accumulator flags plain");
        mem[8'h00] = 8'hFF; pc = 16'h9002;
        do_pull(8'h28, 1'b0, 8'h00, 8'hEF, "R9 pulled status after wrap R6");
        chk("R6 sp wrapped to 00", {8'd0, sp}, 16'h0000);
        acc_in = 8'h5A; pc = 16'h9003;
        do_push(8'h48, 8'h5A, "R11 pushed accumulator at 0100");
        chk("R4 sp wrapped to FF", {8'd0, sp}, 16'h00FF);
        flags_in = 8'hC3; pc = 16'h9004;
        do_push(8'h08, 8'hF3, "R8 pushed status forces bits 5 and 4");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R3 run did not finish actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule